// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Almost Flags

A 9-bit first-in first-out buffer whose write side and read side run on separate clocks. The two clocks may be one and the same or entirely unrelated. A word enters on a rising write-clock edge only when both write qualifiers are high. A word leaves into a registered output on a rising read-clock edge only when both read qualifiers are high. A separate output enable releases the read bus to high impedance. Depth is a power-of-two parameter, from 64 to 4096 words.

Each side keeps a binary pointer and a Gray copy of it. The Gray copy crosses into the other clock domain through two flip-flops. Full and almost-full are computed on the write clock. Empty and almost-empty are computed on the read clock. Because each side works from a delayed view of the other side's pointer, the flags can only err toward caution. Both thresholds default to 7 words from their end.

The thresholds can be changed while the block runs. With the load input high, qualified writes go into a pair of offset registers and not into the array. The four writes needed for a full update cycle through the empty offset and then the full offset, low part first in each case. The reset is asynchronous and active low, and it reaches both domains.

Top module: `fifo9_dual_clock`

## Requirements
- R1: A word is stored only on a write-clock edge where both write enables are high, load is low and full is low. Words come out in the order they were stored.
- R2: On a read-clock edge where both read enables are high and empty is low, the output register takes the oldest stored word. At every other read edge the output register keeps its value. After reset the output register is 0.
- R3: A qualified write while full is dropped. The write pointer does not move, and the dropped word never appears at the output.
- R4: A qualified read while empty does not move the read pointer and leaves the output register unchanged.
- R5: Once both pointers have settled, full is high exactly when the count equals DEPTH, and empty is high exactly when the count is 0.
- R6: Once settled, almost-empty is high when count <= empty offset, and almost-full is high when count >= DEPTH - full offset. After reset both offsets are 7.
- R7: While load is high, each qualified write (both write enables high) goes to the offset registers in this order: empty offset low part, empty offset high part, full offset low part, full offset high part, then back to the first. A low part is write data bits [min(AW,9)-1:0], where AW = log2(DEPTH). A high part supplies offset bits [AW-1:9] from write data bits [AW-10:0], and it has no effect when AW <= 9.
- R8: Any write-clock edge with load low returns the offset sequence to the empty offset low part.
- R9: A write during load leaves the array and the fill count unchanged.
- R10: With output enable low the read bus is high impedance. Output enable has no effect on the stored output word, and reads proceed while output enable is low.
- R11: Pointers cross domains as Gray code that changes by at most one bit per edge, through two synchronizer stages. With one shared clock, a write at edge k into an empty buffer clears empty after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wen_a_i | input | 1 | First write qualifier |
| wen_b_i | input | 1 | Second write qualifier |
| ld_i | input | 1 | Redirects qualified writes to the offset registers |
| wdata_i | input | 9 | Write data or offset value |
| ren_a_i | input | 1 | First read qualifier |
| ren_b_i | input | 1 | Second read qualifier |
| oe_i | input | 1 | Read bus drive enable |
| rdata_o | output | 9 | Registered read data, high impedance when oe_i is low |
| full_o | output | 1 | Full flag, write clock |
| afull_o | output | 1 | Almost-full flag, write clock |
| empty_o | output | 1 | Empty flag, read clock |
| aempty_o | output | 1 | Almost-empty flag, read clock |

## Verification
The bench builds the block with DEPTH = 64 (AW = 6). Every fill level from empty to full, and back down, is therefore within a few hundred cycles, and each flag boundary is checked at the level where it switches for the default offsets and for several loaded ones. With AW = 6 a high-part offset write has no effect, which the bench relies on. Both clock inputs come from one clock, so the two-stage crossing delay falls on a fixed edge and can be checked exactly.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned DEF_OFF = 7;

  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } off_sel_e;
endpackage

// File: rtl/fifo9_ptr_sync.sv
module fifo9_ptr_sync #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fifo9_offset_regs.sv
module fifo9_offset_regs import fifo9_pkg::*; #(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [AW-1:0]     eoff_o,
  output logic [AW-1:0]     foff_o
);
  localparam int unsigned LO_W = (AW < DATA_W) ? AW : DATA_W;
  localparam int unsigned HI_W = AW - LO_W;

  off_sel_e sel_q;
  logic [AW-1:0] eoff_q, foff_q;
  logic [AW-1:0] e_lo_n, e_hi_n, f_lo_n, f_hi_n;

  if (HI_W > 0) begin : g_hi
    assign e_lo_n = {eoff_q[AW-1:LO_W], data_i[LO_W-1:0]};
    assign f_lo_n = {foff_q[AW-1:LO_W], data_i[LO_W-1:0]};
    assign e_hi_n = {data_i[HI_W-1:0], eoff_q[LO_W-1:0]};
    assign f_hi_n = {data_i[HI_W-1:0], foff_q[LO_W-1:0]};
  end else begin : g_no_hi
    assign e_lo_n = data_i[LO_W-1:0];
    assign f_lo_n = data_i[LO_W-1:0];
    assign e_hi_n = eoff_q;
    assign f_hi_n = foff_q;
  end

  logic unused_data;
  assign unused_data = ^data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_E_LO;
      eoff_q <= AW'(DEF_OFF);
      foff_q <= AW'(DEF_OFF);
    end else if (!ld_i) begin
      sel_q <= SEL_E_LO;
    end else if (wr_i) begin
      sel_q <= off_sel_e'(sel_q + 2'd1);
      unique case (sel_q)
        SEL_E_LO: eoff_q <= e_lo_n;
        SEL_E_HI: eoff_q <= e_hi_n;
        SEL_F_LO: foff_q <= f_lo_n;
        SEL_F_HI: foff_q <= f_hi_n;
        default:  ;
      endcase
    end
  end

  assign eoff_o = eoff_q;
  assign foff_o = foff_q;
endmodule

// File: rtl/fifo9_wr_ctl.sv
module fifo9_wr_ctl #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [AW:0]   rgray_i,
  input  logic [AW-1:0] foff_i,
  output logic          wr_fire_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          afull_o
);
  localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

  logic [AW:0] wbin_q, wgray_q, wbin_n, rbin, cnt;

  always_comb begin
    rbin[AW] = rgray_i[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_i[i];
  end

  assign cnt       = wbin_q - rbin;
  assign full_o    = (cnt == DEPTH_V);
  assign afull_o   = (cnt >= DEPTH_V - {1'b0, foff_i});
  assign wr_fire_o = wr_req_i && !full_o;
  assign wbin_n    = wbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_fire_o) begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
endmodule

// File: rtl/fifo9_rd_ctl.sv
module fifo9_rd_ctl #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [AW:0]   wgray_i,
  input  logic [AW-1:0] eoff_i,
  output logic          rd_fire_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o,
  output logic          aempty_o
);
  logic [AW:0] rbin_q, rgray_q, rbin_n, wbin, cnt;

  always_comb begin
    wbin[AW] = wgray_i[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
  end

  assign cnt       = wbin - rbin_q;
  assign empty_o   = (cnt == '0);
  assign aempty_o  = (cnt <= {1'b0, eoff_i});
  assign rd_fire_o = rd_req_i && !empty_o;
  assign rbin_n    = rbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_fire_o) begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
endmodule

// File: rtl/fifo9_dual_clock.sv
module fifo9_dual_clock import fifo9_pkg::*; #(
  parameter int unsigned DEPTH = 256
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_a_i,
  input  logic              wen_b_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_a_i,
  input  logic              ren_b_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              afull_o,
  output logic              empty_o,
  output logic              aempty_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic              wr_both, rd_both, wr_fire, rd_fire;
  logic [AW-1:0]     waddr, raddr, eoff, foff;
  logic [AW:0]       wgray, rgray, wgray_rs, rgray_ws;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  assign wr_both = wen_a_i && wen_b_i;
  assign rd_both = ren_a_i && ren_b_i;

  fifo9_offset_regs #(.AW(AW)) i_offsets (
    .clk_i(wclk_i), .rst_ni(rst_ni), .ld_i(ld_i), .wr_i(wr_both),
    .data_i(wdata_i), .eoff_o(eoff), .foff_o(foff)
  );

  fifo9_wr_ctl #(.AW(AW)) i_wr_ctl (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wr_req_i(wr_both && !ld_i),
    .rgray_i(rgray_ws), .foff_i(foff), .wr_fire_o(wr_fire),
    .waddr_o(waddr), .wgray_o(wgray), .full_o(full_o), .afull_o(afull_o)
  );

  fifo9_ptr_sync #(.W(AW + 1)) i_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  fifo9_ptr_sync #(.W(AW + 1)) i_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  fifo9_rd_ctl #(.AW(AW)) i_rd_ctl (
    .clk_i(rclk_i), .rst_ni(rst_ni), .rd_req_i(rd_both),
    .wgray_i(wgray_rs), .eoff_i(eoff), .rd_fire_o(rd_fire),
    .raddr_o(raddr), .rgray_o(rgray), .empty_o(empty_o), .aempty_o(aempty_o)
  );

  always_ff @(posedge wclk_i) begin
    if (wr_fire) mem_q[waddr] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_fire) rd_q <= mem_q[raddr];
  end

  assign rdata_o = oe_i ? rd_q : 'z;
endmodule

// File: rtl/fifo9_chk.sv
module fifo9_chk #(
  parameter int unsigned AW = 8
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wr_both_i,
  input logic        ld_i,
  input logic        rd_both_i,
  input logic        full_i,
  input logic        afull_i,
  input logic        empty_i,
  input logic        aempty_i,
  input logic [AW:0] wgray_i,
  input logic [AW:0] rgray_i,
  input logic [8:0]  rd_q_i
);
  // R3
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_i && wr_both_i && !ld_i) |=> $stable(wgray_i));

  // R4
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_i && rd_both_i) |=> ($stable(rgray_i) && $stable(rd_q_i)));

  // R2
  rdata_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_both_i |=> $stable(rd_q_i));

  // R9
  load_no_store_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (ld_i && wr_both_i) |=> $stable(wgray_i));

  // R11
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(wgray_i ^ $past(wgray_i)) <= 1));

  // R11
  rgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(rgray_i ^ $past(rgray_i)) <= 1));

  // R6
  full_afull_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_i |-> afull_i);

  // R6
  empty_aempty_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_i |-> aempty_i);
endmodule

bind fifo9_dual_clock fifo9_chk #(.AW(AW)) i_fifo9_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wr_both_i(wr_both), .ld_i(ld_i), .rd_both_i(rd_both),
  .full_i(full_o), .afull_i(afull_o), .empty_i(empty_o), .aempty_i(aempty_o),
  .wgray_i(wgray), .rgray_i(rgray), .rd_q_i(rd_q)
);

// File: tb/test_fifo9_dual_clock.sv
`timescale 1ns/1ps
module test_fifo9_dual_clock;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int LO_W  = (AW < 9) ? AW : 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen_a = 0, wen_b = 0, ren_a = 0, ren_b = 0, ld = 0, oe = 1;
  logic [8:0] wdata = '0;
  wire  [8:0] rdata;
  wire full, afull, empty, aempty;

  int n_chk = 0, n_err = 0;
  int mq[$];
  int exp_rd = 0;
  int eoff = 7, foff = 7, sel = 0;

  always #2.5 clk = ~clk;

  fifo9_dual_clock #(.DEPTH(DEPTH)) i_fifo9_dual_clock (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .wen_a_i(wen_a), .wen_b_i(wen_b), .ld_i(ld), .wdata_i(wdata),
    .ren_a_i(ren_a), .ren_b_i(ren_b), .oe_i(oe), .rdata_o(rdata),
    .full_o(full), .afull_o(afull), .empty_o(empty), .aempty_o(aempty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  function automatic int put_lo(input int cur, input int d);
    int m = (1 << LO_W) - 1;
    return (cur & ~m) | (d & m);
  endfunction

  function automatic int put_hi(input int cur, input int d);
    int m = (1 << LO_W) - 1;
    if (AW <= LO_W) return cur;
    return (cur & m) | ((d & ((1 << (AW - LO_W)) - 1)) << LO_W);
  endfunction

  // one write/read clock cycle; inputs driven and outputs sampled at negedge
  task automatic step(input bit wa, input bit wb, input bit ra, input bit rb,
                      input int d, input bit l);
    bit wf, rf, held;
    wf = wa && wb && !l && !full;
    rf = ra && rb && !empty;
    wen_a = wa; wen_b = wb; ren_a = ra; ren_b = rb; wdata = 9'(d); ld = l;
    @(posedge clk);
    @(negedge clk);
    held = (ra && rb && empty);
    if (!l) sel = 0;
    else if (wa && wb) begin
      case (sel)
        0: eoff = put_lo(eoff, d);
        1: eoff = put_hi(eoff, d);
        2: foff = put_lo(foff, d);
        default: foff = put_hi(foff, d);
      endcase
      sel = (sel + 1) % 4;
    end
    if (rf) exp_rd = mq.pop_front();
    if (wf) mq.push_back(d);
    if (oe) begin
      if (held) chk(rdata == 9'(exp_rd), "R4 read while empty holds", int'(rdata), exp_rd);
      else      chk(rdata == 9'(exp_rd), "R2 read data", int'(rdata), exp_rd);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic settle();
    int c;
    idle(4);
    c = mq.size();
    chk(full == (c == DEPTH), "R5 full", int'(full), int'(c == DEPTH));
    chk(empty == (c == 0), "R5 empty", int'(empty), int'(c == 0));
    chk(aempty == (c <= eoff), "R6 almost-empty", int'(aempty), int'(c <= eoff));
    chk(afull == (c >= DEPTH - foff), "R6 almost-full", int'(afull), int'(c >= DEPTH - foff));
  endtask

  task automatic fill_to(input int n);
    while (mq.size() < n) begin
      step(1, 1, 0, 0, int'($urandom_range(0, 511)), 0);
      settle();
    end
  endtask

  task automatic drain_to(input int n);
    while (mq.size() > n) begin
      step(0, 0, 1, 1, 0, 0);
      settle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R2, R5, R6)
    chk(rdata == 9'd0, "R2 reset rdata", int'(rdata), 0);
    chk(empty && aempty, "R5 reset empty", int'(empty && aempty), 1);
    chk(!full && !afull, "R5 reset full", int'(full || afull), 0);

    // R11: crossing latency, same clock
    step(1, 1, 0, 0, 9'h1A5, 0);
    chk(empty == 1'b1, "R11 empty after edge k", int'(empty), 1);
    idle(1);
    chk(empty == 1'b1, "R11 empty after edge k+1", int'(empty), 1);
    idle(1);
    chk(empty == 1'b0, "R11 empty after edge k+2", int'(empty), 0);
    step(0, 0, 1, 1, 0, 0);
    chk(rdata == 9'h1A5, "R2 first word", int'(rdata), 'h1A5);
    settle();

    // R4: read on empty, R1: one enable alone does not write
    step(0, 0, 1, 1, 0, 0);
    step(1, 0, 0, 0, 9'h055, 0);
    step(0, 1, 0, 0, 9'h0AA, 0);
    settle();
    chk(mq.size() == 0, "R1 single enable no write", mq.size(), 0);

    // R6 default thresholds, R3 write at full, R5
    fill_to(DEPTH);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 9'h1FF, 0);
    settle();
    chk(mq.size() == DEPTH, "R3 writes at full dropped", mq.size(), DEPTH);
    drain_to(DEPTH - 2);

    // R10: reads go on with oe low; stored word kept
    oe = 0;
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    oe = 1;
    #0.1;
    chk(rdata == 9'(exp_rd), "R10 oe re-enable shows word", int'(rdata), exp_rd);
    drain_to(0);

    // R7/R9: load offsets 10 and 20
    step(1, 1, 0, 0, 10, 1);
    step(1, 1, 0, 0, 3, 1);
    step(1, 1, 0, 0, 20, 1);
    step(1, 1, 0, 0, 5, 1);
    settle();
    chk(mq.size() == 0 && empty, "R9 load writes not stored", int'(empty), 1);
    chk(eoff == 10 && foff == 20, "R7 model offsets", eoff, 10);
    fill_to(DEPTH);
    drain_to(0);

    // R7 wrap: fifth load write lands in empty offset low
    step(1, 1, 0, 0, 3, 1);
    step(1, 1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 4, 1);
    step(1, 1, 0, 0, 0, 1);
    step(1, 1, 0, 0, 12, 1);
    // R8: load low restarts the sequence
    step(1, 1, 0, 0, 9, 1);
    step(0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 15, 1);
    settle();
    chk(eoff == 15 && foff == 4, "R8 model offsets", eoff, 15);
    fill_to(DEPTH);
    drain_to(0);

    // constrained random traffic (R1, R2, R3, R4)
    for (int n = 0; n < 4000; n++) begin
      bit wb_en, rb_en;
      wb_en = ($urandom_range(0, 3) != 0);
      rb_en = ($urandom_range(0, 3) != 0);
      step(wb_en, ($urandom_range(0, 4) != 0), rb_en, ($urandom_range(0, 5) != 0),
           int'($urandom_range(0, 511)), 0);
      if (n % 250 == 249) settle();
    end
    settle();
    drain_to(0);
    finish_run();
  end
endmodule